// File: doc/BRIEF.md
# Masked Privileged Control Register Bank

This block holds the privileged control state of a processor core: two dozen scratch words, a set of control registers that each keep only their own defined bits, two exception status words, six read-only status views and eight command slots. One read port and one write port are reached by a register index. They share a 64-bit data path. Every access is checked against the class of the register it targets. An access that is illegal for that register, or that names no register at all, raises a one-cycle fault flag and changes nothing.

A write to a command slot stores nothing. It emits a one-cycle pulse that the cache and translation buffer logic outside the block turn into a flush or an invalidate. The two exception status words gather event bits from hardware and are cleared by any software write. A legal read of the faulting-address view also releases the interrupt status lock. Read data, the fault flag, the command pulses and the lock are all registered and appear one cycle after the strobe.

Top module: `ctlreg_file`

## Requirements
- R1: Indices 0 to 23 are scratch words that keep all 64 written bits. The read data of an accepted read appears on `rd_data_o` in the cycle after the read strobe and holds until the next read.
- R2: Writes keep only their own bits in these registers: index 32 and index 33 keep bits 3:0, index 34 keeps bits 4:0, and index 35 keeps bits 4:3 (mask 0x18).
- R3: Writes are masked in these registers: index 37 keeps 0x7FFF0, index 38 keeps 0xFF_FFFF_0300, indices 39 and 40 keep bits 63:30, indices 41 and 42 keep bits 5:0, index 43 keeps 0x1FFB, index 44 keeps 0x7F0, and index 45 keeps bits 63:57.
- R4: Index 46 ORs in `exc_sum_set_i` and index 47 ORs in `exc_mask_set_i` every cycle. Any write to either register clears it, except that bits set in the same cycle as the write survive.
- R5: Indices 48 to 53 read `ro_value_i[index-48]`. A write to any of them is faulted.
- R6: Index 36 and indices 56 to 63 are write-only. A read of one of them returns 0 and is faulted. A write to index 56+k gives a single-cycle pulse on `cmd_pulse_o[k]` in the next cycle. A write to index 36 keeps bits 4:3, shown on `alt_mode_o`, and gives no pulse.
- R7: `lock_set_i` sets `intr_lock_o` in the next cycle. A read of index 53 without `lock_set_i` in the same cycle clears it in the next cycle. A read of any other index leaves the lock as it is.
- R8: Indices 24 to 31, 54, 55 and 64 and above fault on both read and write. A faulted read returns 0. A faulted write changes no stored value.
- R9: After reset, all stored registers, `rd_data_o`, `fault_o`, `cmd_pulse_o`, `intr_lock_o` and `alt_mode_o` are zero.
- R10: `fault_o` is high for exactly the one cycle after an illegal access strobe and is low after a cycle with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en_i | input | 1 | Read strobe |
| rd_idx_i | input | IDX_W | Read register index |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | IDX_W | Write register index |
| wr_data_i | input | 64 | Write data |
| exc_sum_set_i | input | 64 | Event bits ORed into the exception summary word |
| exc_mask_set_i | input | 64 | Event bits ORed into the exception mask word |
| ro_value_i | input | 6x64 | Values seen by the read-only indices |
| lock_set_i | input | 1 | Sets the interrupt status lock |
| rd_data_o | output | 64 | Registered read data |
| fault_o | output | 1 | Illegal access flag, one cycle after the strobe |
| cmd_pulse_o | output | 8 | One-hot command pulses for flush and invalidate slots |
| intr_lock_o | output | 1 | Interrupt status lock |
| alt_mode_o | output | 2 | Stored alternate mode bits |

## Verification
Every result is one register stage behind its strobe: read data, the fault flag and the command pulses are all due in the cycle after the strobe. Stored values written at one edge can be read back by the strobe in the next cycle. The bench drives each strobe on a falling edge for one cycle and samples the outputs at the following falling edge, halfway through the cycle in which they are valid. It takes a second sample one cycle later where a pulse has to fall again. The lock and the exception event inputs are timed the same way: they are driven for one cycle, and their effect is observed one cycle later.

// File: rtl/ctlreg_pkg.sv
`timescale 1ns/1ps
package ctlreg_pkg;
  localparam int DATA_W      = 64;
  localparam int SCRATCH_N   = 24;
  localparam int MASKED_BASE = 32;
  localparam int MASKED_N    = 16;
  localparam int NUM_SLOTS   = SCRATCH_N + MASKED_N;
  localparam int SLOT_W      = $clog2(NUM_SLOTS);
  localparam int IX_ALT      = 36;
  localparam int IX_SUM      = 46;
  localparam int IX_EMASK    = 47;
  localparam int RO_BASE     = 48;
  localparam int NUM_RO      = 6;
  localparam int RO_W        = $clog2(NUM_RO);
  localparam int IX_FVA      = 53;
  localparam int CMD_BASE    = 56;
  localparam int NUM_CMD     = 8;
  localparam int CMD_W       = $clog2(NUM_CMD);
  localparam int ALT_SLOT    = IX_ALT - MASKED_BASE + SCRATCH_N;
  localparam int SUM_SLOT    = IX_SUM - MASKED_BASE + SCRATCH_N;
  localparam int EMASK_SLOT  = IX_EMASK - MASKED_BASE + SCRATCH_N;

  typedef enum logic [2:0] {ACC_NONE, ACC_RW, ACC_CLR, ACC_RO, ACC_WO} acc_e;

  typedef struct packed {
    acc_e              acc;
    logic              stored;
    logic              cmd;
    logic [SLOT_W-1:0] slot;
    logic [RO_W-1:0]   ro_sel;
    logic [CMD_W-1:0]  cmd_sel;
    logic [DATA_W-1:0] mask;
  } dec_t;

  function automatic dec_t decode_index(input int unsigned ix);
    dec_t d;
    d     = '0;
    d.acc = ACC_NONE;
    if (ix < SCRATCH_N) begin
      d.acc    = ACC_RW;
      d.stored = 1'b1;
      d.mask   = '1;
      d.slot   = SLOT_W'(ix);
    end else if (ix >= MASKED_BASE && ix < MASKED_BASE + MASKED_N) begin
      d.acc    = ACC_RW;
      d.stored = 1'b1;
      d.slot   = SLOT_W'(ix - MASKED_BASE + SCRATCH_N);
      case (ix)
        32, 33:  d.mask = 64'h0000_0000_0000_000F;
        34:      d.mask = 64'h0000_0000_0000_001F;
        35, 36:  d.mask = 64'h0000_0000_0000_0018;
        37:      d.mask = 64'h0000_0000_0007_FFF0;
        38:      d.mask = 64'h0000_00FF_FFFF_0300;
        39, 40:  d.mask = 64'hFFFF_FFFF_C000_0000;
        41, 42:  d.mask = 64'h0000_0000_0000_003F;
        43:      d.mask = 64'h0000_0000_0000_1FFB;
        44:      d.mask = 64'h0000_0000_0000_07F0;
        45:      d.mask = 64'hFE00_0000_0000_0000;
        default: d.mask = '0;  // clear-on-write words keep nothing
      endcase
      if (ix == IX_ALT) d.acc = ACC_WO;
      if (ix == IX_SUM || ix == IX_EMASK) d.acc = ACC_CLR;
    end else if (ix >= RO_BASE && ix < RO_BASE + NUM_RO) begin
      d.acc    = ACC_RO;
      d.ro_sel = RO_W'(ix - RO_BASE);
    end else if (ix >= CMD_BASE && ix < CMD_BASE + NUM_CMD) begin
      d.acc     = ACC_WO;
      d.cmd     = 1'b1;
      d.cmd_sel = CMD_W'(ix - CMD_BASE);
    end
    return d;
  endfunction
endpackage

// File: rtl/ctlreg_decode.sv
`timescale 1ns/1ps
module ctlreg_decode
  import ctlreg_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic [IDX_W-1:0] idx_i,
  output dec_t             dec_o
);
  always_comb dec_o = decode_index(32'(idx_i));
endmodule

// File: rtl/ctlreg_bank.sv
`timescale 1ns/1ps
module ctlreg_bank
  import ctlreg_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en_i,
  input  logic [SLOT_W-1:0]                 wr_slot_i,
  input  logic [DATA_W-1:0]                 wr_val_i,
  input  logic [DATA_W-1:0]                 sum_set_i,
  input  logic [DATA_W-1:0]                 emask_set_i,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]  q_o
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [DATA_W-1:0] set_bits;
    logic [DATA_W-1:0] nxt;
    logic              hit;
    logic              en;

    if (s == SUM_SLOT) begin : g_sum
      assign set_bits = sum_set_i;
    end else if (s == EMASK_SLOT) begin : g_emask
      assign set_bits = emask_set_i;
    end else begin : g_plain
      assign set_bits = '0;
    end

    always_comb begin
      hit = wr_en_i && (wr_slot_i == SLOT_W'(s));
      en  = hit || (|set_bits);
      nxt = (hit ? wr_val_i : q_o[s]) | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q_o[s] <= '0;
      else if (en) q_o[s] <= nxt;
    end
  end
endmodule

// File: rtl/ctlreg_file.sv
`timescale 1ns/1ps
module ctlreg_file
  import ctlreg_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en_i,
  input  logic [IDX_W-1:0]              rd_idx_i,
  input  logic                          wr_en_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  logic [63:0]                   wr_data_i,
  input  logic [63:0]                   exc_sum_set_i,
  input  logic [63:0]                   exc_mask_set_i,
  input  logic [5:0][63:0]              ro_value_i,
  input  logic                          lock_set_i,
  output logic [63:0]                   rd_data_o,
  output logic                          fault_o,
  output logic [7:0]                    cmd_pulse_o,
  output logic                          intr_lock_o,
  output logic [1:0]                    alt_mode_o
);
  dec_t rd_dec, wr_dec;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] bank_q;
  logic              wr_legal, wr_bad, rd_bad, store_we;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rd_data_d;
  logic              fault_d;
  logic [NUM_CMD-1:0] cmd_d;
  logic              lock_d;

  ctlreg_decode #(.IDX_W(IDX_W)) u_rd_dec (.idx_i(rd_idx_i), .dec_o(rd_dec));
  ctlreg_decode #(.IDX_W(IDX_W)) u_wr_dec (.idx_i(wr_idx_i), .dec_o(wr_dec));

  always_comb begin
    wr_legal = wr_en_i && (wr_dec.acc inside {ACC_RW, ACC_CLR, ACC_WO});
    wr_bad   = wr_en_i && (wr_dec.acc inside {ACC_NONE, ACC_RO});
    rd_bad   = rd_en_i && (rd_dec.acc inside {ACC_NONE, ACC_WO});
    store_we = wr_legal && wr_dec.stored;
  end

  ctlreg_bank u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (store_we),
    .wr_slot_i   (wr_dec.slot),
    .wr_val_i    (wr_data_i & wr_dec.mask),
    .sum_set_i   (exc_sum_set_i),
    .emask_set_i (exc_mask_set_i),
    .q_o         (bank_q)
  );

  // read mux and next-state
  always_comb begin
    unique case (rd_dec.acc)
      ACC_RW, ACC_CLR: rd_val = bank_q[rd_dec.slot];
      ACC_RO:          rd_val = ro_value_i[rd_dec.ro_sel];
      default:         rd_val = '0;
    endcase
    rd_data_d = rd_bad ? '0 : rd_val;
    fault_d   = rd_bad || wr_bad;
    cmd_d     = '0;
    if (wr_legal && wr_dec.cmd) cmd_d[wr_dec.cmd_sel] = 1'b1;
    lock_d = intr_lock_o;
    if (rd_en_i && !rd_bad && rd_idx_i == IDX_W'(IX_FVA)) lock_d = 1'b0;
    if (lock_set_i) lock_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_o   <= '0;
      fault_o     <= 1'b0;
      cmd_pulse_o <= '0;
      intr_lock_o <= 1'b0;
    end else begin
      if (rd_en_i) rd_data_o <= rd_data_d;
      fault_o     <= fault_d;
      cmd_pulse_o <= cmd_d;
      intr_lock_o <= lock_d;
    end
  end

  assign alt_mode_o = bank_q[ALT_SLOT][4:3];
endmodule

// File: rtl/ctlreg_file_chk.sv
`timescale 1ns/1ps
module ctlreg_file_chk
  import ctlreg_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en_i,
  input logic [IDX_W-1:0] rd_idx_i,
  input logic             wr_en_i,
  input logic             lock_set_i,
  input logic [63:0]      rd_data_o,
  input logic             fault_o,
  input logic [7:0]       cmd_pulse_o,
  input logic             intr_lock_o,
  input logic [1:0]       alt_mode_o
);
  p_cmd_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_pulse_o));

  p_cmd_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i) |=> (cmd_pulse_o == '0));

  p_alt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i) |=> $stable(alt_mode_o));

  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_i && !wr_en_i) |=> !fault_o);

  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_i) |=> $stable(rd_data_o));

  p_lock_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_set_i |=> intr_lock_o);

  p_lock_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_idx_i == IDX_W'(IX_FVA) && !lock_set_i) |=> !intr_lock_o);
endmodule

bind ctlreg_file ctlreg_file_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_en_i     (rd_en_i),
  .rd_idx_i    (rd_idx_i),
  .wr_en_i     (wr_en_i),
  .lock_set_i  (lock_set_i),
  .rd_data_o   (rd_data_o),
  .fault_o     (fault_o),
  .cmd_pulse_o (cmd_pulse_o),
  .intr_lock_o (intr_lock_o),
  .alt_mode_o  (alt_mode_o)
);

// File: tb/test_ctlreg_file.sv
`timescale 1ns/1ps
module test_ctlreg_file;
  localparam int IW = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rd_en = 1'b0;
  logic [IW-1:0]    rd_idx = '0;
  logic             wr_en = 1'b0;
  logic [IW-1:0]    wr_idx = '0;
  logic [63:0]      wr_data = '0;
  logic [63:0]      sum_set = '0;
  logic [63:0]      emask_set = '0;
  logic [5:0][63:0] ro_val = '0;
  logic             lock_set = 1'b0;
  logic [63:0]      rd_data;
  logic             fault;
  logic [7:0]       cmd;
  logic             lock;
  logic [1:0]       alt;

  int checks = 0;
  int errors = 0;
  logic        w_fault, r_fault;
  logic [7:0]  w_cmd;
  logic [63:0] r_data;

  always #10 clk = ~clk;

  ctlreg_file #(.IDX_W(IW)) i_ctlreg_file (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en), .rd_idx_i(rd_idx),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .exc_sum_set_i(sum_set), .exc_mask_set_i(emask_set), .ro_value_i(ro_val),
    .lock_set_i(lock_set), .rd_data_o(rd_data), .fault_o(fault),
    .cmd_pulse_o(cmd), .intr_lock_o(lock), .alt_mode_o(alt)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input int idx, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    w_fault = fault; w_cmd = cmd;
  endtask

  task automatic do_rd(input int idx);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = IW'(idx);
    @(negedge clk);
    rd_en = 1'b0;
    r_data = rd_data; r_fault = fault;
  endtask

  task automatic t_reset;
    chk("R9 rd_data", rd_data, 0);
    chk("R9 fault", 64'(fault), 0);
    chk("R9 cmd", 64'(cmd), 0);
    chk("R9 lock", 64'(lock), 0);
    chk("R9 alt", 64'(alt), 0);
    do_rd(34); chk("R9 stored ipl", r_data, 0);
  endtask

  task automatic t_scratch;
    do_wr(0, 64'h0123_4567_89AB_CDEF); chk("R1 wr fault", 64'(w_fault), 0);
    do_wr(23, 64'hFEDC_BA98_7654_3210);
    do_rd(0);  chk("R1 idx0", r_data, 64'h0123_4567_89AB_CDEF);
    chk("R1 rd fault", 64'(r_fault), 0);
    do_rd(23); chk("R1 idx23", r_data, 64'hFEDC_BA98_7654_3210);
    @(negedge clk); chk("R1 hold", rd_data, 64'hFEDC_BA98_7654_3210);
  endtask

  task automatic t_masks_a;
    logic [63:0] exp [4] = '{64'hF, 64'hF, 64'h1F, 64'h18};
    for (int k = 0; k < 4; k++) begin
      do_wr(32 + k, '1);
      do_rd(32 + k); chk($sformatf("R2 idx%0d", 32 + k), r_data, exp[k]);
    end
  endtask

  task automatic t_masks_b;
    logic [63:0] exp [9] = '{64'h7FFF0, 64'hFF_FFFF_0300, 64'hFFFF_FFFF_C000_0000,
                             64'hFFFF_FFFF_C000_0000, 64'h3F, 64'h3F, 64'h1FFB,
                             64'h7F0, 64'hFE00_0000_0000_0000};
    for (int k = 0; k < 9; k++) begin
      do_wr(37 + k, '1);
      do_rd(37 + k); chk($sformatf("R3 idx%0d", 37 + k), r_data, exp[k]);
    end
  endtask

  task automatic t_clear;
    @(negedge clk); sum_set = 64'hA5;
    @(negedge clk); sum_set = '0;
    do_rd(46); chk("R4 sum set", r_data, 64'hA5);
    do_wr(46, '1); chk("R4 wr fault", 64'(w_fault), 0);
    do_rd(46); chk("R4 sum cleared", r_data, 0);
    @(negedge clk); wr_en = 1'b1; wr_idx = IW'(47); wr_data = '1; emask_set = 64'h3C;
    @(negedge clk); wr_en = 1'b0; emask_set = '0;
    do_rd(47); chk("R4 set survives clear", r_data, 64'h3C);
  endtask

  task automatic t_readonly;
    for (int k = 0; k < 6; k++) ro_val[k] = 64'h1000 + 64'(k) * 64'h111;
    for (int k = 0; k < 6; k++) begin
      do_rd(48 + k); chk($sformatf("R5 ro%0d", k), r_data, 64'h1000 + 64'(k) * 64'h111);
    end
    do_wr(50, 64'hDEAD); chk("R5 write fault", 64'(w_fault), 1);
    do_rd(0); chk("R5 R8 no side write", r_data, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_writeonly;
    do_rd(36); chk("R6 alt read data", r_data, 0); chk("R6 alt read fault", 64'(r_fault), 1);
    do_rd(58); chk("R6 cmd read data", r_data, 0); chk("R6 cmd read fault", 64'(r_fault), 1);
    do_wr(58, 64'h1); chk("R6 pulse", 64'(w_cmd), 64'h04); chk("R6 no fault", 64'(w_fault), 0);
    @(negedge clk); chk("R6 pulse falls", 64'(cmd), 0);
    do_wr(63, 64'h0); chk("R6 pulse top", 64'(w_cmd), 64'h80);
    do_wr(36, 64'hFF); chk("R6 alt no pulse", 64'(w_cmd), 0);
    chk("R6 alt mode", 64'(alt), 64'h3);
    do_wr(36, 64'h08); chk("R6 alt mode low", 64'(alt), 64'h1);
  endtask

  task automatic t_lock;
    @(negedge clk); lock_set = 1'b1;
    @(negedge clk); lock_set = 1'b0; chk("R7 lock set", 64'(lock), 1);
    do_rd(49); chk("R7 other read keeps", 64'(lock), 1);
    do_rd(53); chk("R7 va read releases", 64'(lock), 0);
  endtask

  task automatic t_unknown;
    int bad [5] = '{24, 31, 54, 55, 100};
    foreach (bad[k]) begin
      do_rd(bad[k]); chk($sformatf("R8 rd fault %0d", bad[k]), 64'(r_fault), 1);
      chk($sformatf("R8 rd zero %0d", bad[k]), r_data, 0);
      do_wr(bad[k], 64'h5555); chk($sformatf("R8 wr fault %0d", bad[k]), 64'(w_fault), 1);
    end
    do_rd(0); chk("R8 state unchanged", r_data, 64'h0123_4567_89AB_CDEF);
    do_rd(23); chk("R8 state unchanged 23", r_data, 64'hFEDC_BA98_7654_3210);
  endtask

  task automatic t_fault_timing;
    do_rd(30); chk("R10 fault high", 64'(r_fault), 1);
    @(negedge clk); chk("R10 fault falls", 64'(fault), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_scratch();
    t_masks_a();
    t_masks_b();
    t_clear();
    t_readonly();
    t_writeonly();
    t_lock();
    t_unknown();
    t_fault_timing();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule